// File: doc/BRIEF.md
# SPI Register and FIFO Command Decoder

This block is an SPI target placed in front of a contactless front-end's register file, its 512-byte data FIFO and its passive-target configuration memory. The host frames every transaction with an active-low chip select and clocks it in SPI mode 0, most significant bit first. The first byte of each frame is an operation byte. It selects one of the following: a register read, a register write, a direct command, a FIFO load, a FIFO read, one of three configuration-memory loads, or a configuration readback. The bytes after it are moved to or from the selected resource.

Two direct-command codes act as prefixes rather than commands. One steers the next read or write byte of the same frame to an alternate register bank. The other steers it to a test bank, which takes exactly one data byte. Every prefix and every pending operation is dropped when chip select goes high. A byte that is cut short by chip select rising is discarded. The FIFO is shared with the front-end core, which pushes received data and pops transmit data through its own port. Overflow and underflow are recorded in sticky flags that only reset clears.

The SPI pins are sampled by the system clock through synchronizers. The SPI clock half period must therefore be at least eight system clock cycles.

Top module: `spi_fe_decoder`

## Requirements
- R1: After reset, MISO is 0, the FIFO level is 0, both FIFO flags are 0 and no strobe (reg_we, cfg_we, cmd_stb) is active.
- R2: An operation byte 00aaaaaa followed by N complete data bytes gives N single-cycle reg_we pulses on bank 0 (main), at addresses a, a+1, ... (6-bit wrap), each carrying its data byte.
- R3: An operation byte 01aaaaaa returns reg_rdata for addresses a, a+1, ... (6-bit wrap) on MISO, MSB first, one byte per following byte slot.
- R4: An operation byte 11cccccc, where cccccc is neither prefix code, gives one cmd_stb pulse with cmd_code = cccccc. The next byte in the same frame is decoded again as an operation byte.
- R5: Byte 0xFB (command code 0x3B) makes the next read or write byte of the same frame use bank 1, with bursts allowed. After chip select rises, accesses use bank 0 again.
- R6: Byte 0xFC (command code 0x3C) makes the next read or write byte use bank 2 (test). Exactly one data byte is written or returned. Later bytes in the frame write nothing and read back 0x00.
- R7: Byte 0x80 pushes every following complete byte into the FIFO. A push into a full FIFO (512 entries) is dropped, the level stays the same, and fifo_ovf is set and stays set.
- R8: Byte 0x9F shifts FIFO bytes out in order for as long as chip select stays low. A byte slot that finds the FIFO empty returns 0x00 and sets fifo_udf, which stays set.
- R9: Bytes 0xA0, 0xA8 and 0xAC write the following bytes to configuration addresses starting at 0, 15 and 36 respectively. The address rises by one per byte.
- R10: Byte 0xBF returns 0x00 in the first following slot, then cfg_rdata for configuration addresses 0, 1, 2, ...
- R11: When chip select rises part-way through a byte, that byte causes no write, push or strobe. The next frame is decoded normally.
- R12: An operation byte with top bits 10 that is not one of the six listed values makes the rest of the frame have no effect, and the block returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| reg_we | output | 1 | Register write strobe |
| reg_bank | output | 2 | Register bank: 0 main, 1 alternate, 2 test |
| reg_addr | output | 6 | Register address for read and write |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for reg_bank/reg_addr |
| cfg_we | output | 1 | Configuration memory write strobe |
| cfg_addr | output | CFG_AW | Configuration memory address for write and read |
| cfg_wdata | output | 8 | Configuration memory write data |
| cfg_rdata | input | 8 | Configuration memory read data at cfg_addr |
| cmd_stb | output | 1 | Direct command strobe |
| cmd_code | output | 6 | Direct command code |
| core_push | input | 1 | Core-side FIFO push |
| core_wdata | input | 8 | Core-side FIFO push data |
| core_pop | input | 1 | Core-side FIFO pop |
| core_rdata | output | 8 | FIFO head (show-ahead) |
| fifo_level | output | $clog2(FIFO_DEPTH)+1 | FIFO occupancy |
| fifo_ovf | output | 1 | Sticky overflow flag |
| fifo_udf | output | 1 | Sticky underflow flag |

## Verification
The hardest state to reach from the SPI pins is a full FIFO. Filling it through SPI would take 512 byte slots. The bench therefore fills it in 512 cycles through the core push port, then attempts one more load over SPI and reads the oldest entries back. The other awkward cases are underflow and truncated bytes. For underflow, the bench clocks more read slots than the FIFO holds. For a truncated byte, it raises chip select after a few bits of a data byte, and then checks that a following normal frame still decodes.

// File: rtl/spi_dec_pkg.sv
// Package: shared state, bank and operation-byte definitions for the
// SPI front-end decoder. Assumes byte-wide SPI transfers.
package spi_dec_pkg;

    typedef enum logic [2:0] {
        ST_OP   = 3'd0,
        ST_WR   = 3'd1,
        ST_RD   = 3'd2,
        ST_FLD  = 3'd3,
        ST_FRD  = 3'd4,
        ST_CLD  = 3'd5,
        ST_CRD  = 3'd6,
        ST_SKIP = 3'd7
    } dec_state_e;

    typedef enum logic [1:0] {
        BK_MAIN = 2'd0,
        BK_ALT  = 2'd1,
        BK_TEST = 2'd2
    } bank_e;

    localparam logic [1:0] MODE_WRITE = 2'b00;
    localparam logic [1:0] MODE_READ  = 2'b01;
    localparam logic [1:0] MODE_SPEC  = 2'b10;
    localparam logic [1:0] MODE_CMD   = 2'b11;

    localparam logic [7:0] OPB_FIFO_PUSH = 8'h80;
    localparam logic [7:0] OPB_FIFO_PULL = 8'h9F;
    localparam logic [7:0] OPB_CFG_A     = 8'hA0;
    localparam logic [7:0] OPB_CFG_F     = 8'hA8;
    localparam logic [7:0] OPB_CFG_T     = 8'hAC;
    localparam logic [7:0] OPB_CFG_READ  = 8'hBF;

endpackage

// File: rtl/spi_dec_shifter.sv
// Module: spi_dec_shifter
// Synchronizes the SPI pins into clk and assembles received bytes. It also
// shifts the transmit byte out on MISO.
// Assumes SPI mode 0, MSB first, and an SCK half period of at least
// SYNC_STAGES+6 clk cycles. A new transmit byte is taken on the first SCK
// fall after a complete byte.
module spi_dec_shifter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic [7:0] tx_byte,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       frame_end,
    output logic       tx_load,
    output logic       bit_start
);

    logic [SYNC_STAGES-1:0] sclk_q, cs_q, mosi_q;
    logic sclk_s, cs_s, mosi_s, sclk_prev, cs_prev;
    logic [2:0] bitcnt;
    logic [7:0] rx_sh, tx_sh;
    logic       got_byte;
    logic       rise, fall;

    assign sclk_s = sclk_q[SYNC_STAGES-1];
    assign cs_s   = cs_q[SYNC_STAGES-1];
    assign mosi_s = mosi_q[SYNC_STAGES-1];
    assign rise   = sclk_s & ~sclk_prev;
    assign fall   = ~sclk_s & sclk_prev;
    assign spi_miso = tx_sh[7];

    // Pin synchronizers and edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q    <= '0;
            cs_q      <= '1;
            mosi_q    <= '0;
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b1;
        end else begin
            sclk_q    <= {sclk_q[SYNC_STAGES-2:0], spi_sclk};
            cs_q      <= {cs_q[SYNC_STAGES-2:0], spi_cs_n};
            mosi_q    <= {mosi_q[SYNC_STAGES-2:0], spi_mosi};
            sclk_prev <= sclk_s;
            cs_prev   <= cs_s;
        end
    end

    // Bit counting, byte assembly and MISO shifting inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt    <= 3'd0;
            rx_sh     <= 8'h00;
            rx_byte   <= 8'h00;
            tx_sh     <= 8'h00;
            got_byte  <= 1'b0;
            rx_valid  <= 1'b0;
            tx_load   <= 1'b0;
            bit_start <= 1'b0;
            frame_end <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            tx_load   <= 1'b0;
            bit_start <= 1'b0;
            frame_end <= cs_s & ~cs_prev;
            if (cs_s) begin
                bitcnt   <= 3'd0;
                got_byte <= 1'b0;
                tx_sh    <= 8'h00;
            end else begin
                if (rise) begin
                    rx_sh     <= {rx_sh[6:0], mosi_s};
                    bit_start <= (bitcnt == 3'd0);
                    bitcnt    <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) begin
                        rx_valid <= 1'b1;
                        rx_byte  <= {rx_sh[6:0], mosi_s};
                        got_byte <= 1'b1;
                    end
                end
                if (fall) begin
                    if (bitcnt == 3'd0 && got_byte) begin
                        tx_sh   <= tx_byte;
                        tx_load <= 1'b1;
                    end else begin
                        tx_sh <= {tx_sh[6:0], 1'b0};
                    end
                end
            end
        end
    end

    // R11: a byte is only ever delivered from a selected frame
    a_r11_byte_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(!cs_s));

    // R1: MISO is held low while deselected
    a_r1_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_s) && cs_s |-> !spi_miso);

endmodule

// File: rtl/spi_dec_fifo.sv
// Module: spi_dec_fifo
// Show-ahead byte FIFO with one push and one pop port. Sticky overflow and
// underflow flags are cleared only by reset.
// Assumes DEPTH is a power of two. A push into a full FIFO is dropped, even
// when a pop happens in the same cycle.
module spi_dec_fifo #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [LW-1:0]    level,
    output logic             empty,
    output logic             ovf,
    output logic             udf
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             full, do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    // Storage write; no reset on the array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    // Pointer, level and flag upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
            ovf   <= 1'b0;
            udf   <= 1'b0;
        end else begin
            if (do_push) wptr <= wptr + AW'(1);
            if (do_pop)  rptr <= rptr + AW'(1);
            level <= level + LW'(do_push) - LW'(do_pop);
            if (push && full) ovf <= 1'b1;
            if (pop && empty) udf <= 1'b1;
        end
    end

    // R7: a push into a full FIFO leaves the level alone and flags it
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (level == $past(level)) && ovf);

    // R8: popping an empty FIFO keeps it empty and flags it
    a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (level == '0) && udf);

    // R7: occupancy never exceeds the depth
    a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

endmodule

// File: rtl/spi_dec_ctrl.sv
// Module: spi_dec_ctrl
// Decodes the operation byte of each frame and steers the following bytes
// to the register, FIFO or configuration ports. It also picks the byte for
// MISO.
// Assumes rx_valid, tx_load, bit_start and frame_end are single-cycle
// pulses and that no two of them fall in the same cycle.
module spi_dec_ctrl
    import spi_dec_pkg::*;
#(
    parameter int          CFG_AW     = 6,
    parameter int          CFG_F_BASE = 15,
    parameter int          CFG_T_BASE = 36,
    parameter logic [5:0]  ALT_CMD    = 6'h3B,
    parameter logic [5:0]  TEST_CMD   = 6'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              frame_end,
    input  logic              tx_load,
    input  logic              bit_start,
    output logic [7:0]        tx_byte,
    output logic              reg_we,
    output logic [1:0]        reg_bank,
    output logic [5:0]        reg_addr,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata,
    output logic              cfg_we,
    output logic [CFG_AW-1:0] cfg_addr,
    output logic [7:0]        cfg_wdata,
    input  logic [7:0]        cfg_rdata,
    output logic              cmd_stb,
    output logic [5:0]        cmd_code,
    output logic              fifo_push,
    output logic [7:0]        fifo_wdata,
    output logic              fifo_pop,
    input  logic [7:0]        fifo_head,
    input  logic              fifo_empty
);

    localparam logic [CFG_AW-1:0] CFG_ONE = CFG_AW'(1);

    dec_state_e st;
    bank_e      prefix, bank;
    logic       crd_first;

    assign reg_bank = bank;

    // MISO byte for the next slot, chosen by the active operation.
    always_comb begin
        case (st)
            ST_RD:   tx_byte = reg_rdata;
            ST_FRD:  tx_byte = fifo_empty ? 8'h00 : fifo_head;
            ST_CRD:  tx_byte = crd_first ? 8'h00 : cfg_rdata;
            default: tx_byte = 8'h00;
        endcase
    end

    // Operation decode, address stepping and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_OP;
            prefix     <= BK_MAIN;
            bank       <= BK_MAIN;
            reg_addr   <= 6'd0;
            reg_we     <= 1'b0;
            reg_wdata  <= 8'h00;
            cfg_addr   <= '0;
            cfg_we     <= 1'b0;
            cfg_wdata  <= 8'h00;
            crd_first  <= 1'b0;
            cmd_stb    <= 1'b0;
            cmd_code   <= 6'd0;
            fifo_push  <= 1'b0;
            fifo_wdata <= 8'h00;
            fifo_pop   <= 1'b0;
        end else begin
            reg_we    <= 1'b0;
            cfg_we    <= 1'b0;
            cmd_stb   <= 1'b0;
            fifo_push <= 1'b0;
            fifo_pop  <= 1'b0;

            if (reg_we || (tx_load && st == ST_RD)) reg_addr <= reg_addr + 6'd1;
            if (cfg_we) cfg_addr <= cfg_addr + CFG_ONE;
            if (tx_load && st == ST_CRD) begin
                if (crd_first) crd_first <= 1'b0;
                else           cfg_addr  <= cfg_addr + CFG_ONE;
            end
            if (tx_load && st == ST_RD && bank == BK_TEST) st <= ST_SKIP;
            if (bit_start && st == ST_FRD) fifo_pop <= 1'b1;

            if (frame_end) begin
                st     <= ST_OP;
                prefix <= BK_MAIN;
            end else if (rx_valid) begin
                case (st)
                    ST_OP: begin
                        case (rx_byte[7:6])
                            MODE_WRITE, MODE_READ: begin
                                st       <= (rx_byte[7:6] == MODE_WRITE) ? ST_WR : ST_RD;
                                reg_addr <= rx_byte[5:0];
                                bank     <= prefix;
                                prefix   <= BK_MAIN;
                            end
                            MODE_CMD: begin
                                if (rx_byte[5:0] == ALT_CMD) begin
                                    prefix <= BK_ALT;
                                end else if (rx_byte[5:0] == TEST_CMD) begin
                                    prefix <= BK_TEST;
                                end else begin
                                    cmd_stb  <= 1'b1;
                                    cmd_code <= rx_byte[5:0];
                                end
                            end
                            default: begin
                                case (rx_byte)
                                    OPB_FIFO_PUSH: st <= ST_FLD;
                                    OPB_FIFO_PULL: st <= ST_FRD;
                                    OPB_CFG_A: begin
                                        st       <= ST_CLD;
                                        cfg_addr <= '0;
                                    end
                                    OPB_CFG_F: begin
                                        st       <= ST_CLD;
                                        cfg_addr <= CFG_AW'(CFG_F_BASE);
                                    end
                                    OPB_CFG_T: begin
                                        st       <= ST_CLD;
                                        cfg_addr <= CFG_AW'(CFG_T_BASE);
                                    end
                                    OPB_CFG_READ: begin
                                        st        <= ST_CRD;
                                        cfg_addr  <= '0;
                                        crd_first <= 1'b1;
                                    end
                                    default: st <= ST_SKIP;
                                endcase
                            end
                        endcase
                    end
                    ST_WR: begin
                        reg_we    <= 1'b1;
                        reg_wdata <= rx_byte;
                        if (bank == BK_TEST) st <= ST_SKIP;
                    end
                    ST_FLD: begin
                        fifo_push  <= 1'b1;
                        fifo_wdata <= rx_byte;
                    end
                    ST_CLD: begin
                        cfg_we    <= 1'b1;
                        cfg_wdata <= rx_byte;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: consecutive burst writes step the register address by one
    a_r2_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == $past(reg_addr) + 6'd1));

    // R6: a test-bank write is never followed by a second write
    a_r6_test_single: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_bank == BK_TEST) |=> !reg_we);

    // R4: prefix codes never appear as executed commands
    a_r4_cmd_not_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> (cmd_code != ALT_CMD) && (cmd_code != TEST_CMD));

    // R2: at most one resource strobe per cycle
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, cfg_we, cmd_stb, fifo_push, fifo_pop}));

endmodule

// File: rtl/spi_fe_decoder.sv
// Module: spi_fe_decoder (top)
// SPI target that decodes operation bytes for a contactless front-end and
// moves data between the SPI link, the register and configuration ports,
// and an internal shared data FIFO.
// Assumes the core does not push or pop the FIFO while an SPI FIFO
// operation is streaming. SPI wins a same-cycle collision.
module spi_fe_decoder #(
    parameter int         FIFO_DEPTH  = 512,
    parameter int         CFG_AW      = 6,
    parameter int         CFG_F_BASE  = 15,
    parameter int         CFG_T_BASE  = 36,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ALT_CMD     = 6'h3B,
    parameter logic [5:0] TEST_CMD    = 6'h3C
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        spi_sclk,
    input  logic                        spi_cs_n,
    input  logic                        spi_mosi,
    output logic                        spi_miso,
    output logic                        reg_we,
    output logic [1:0]                  reg_bank,
    output logic [5:0]                  reg_addr,
    output logic [7:0]                  reg_wdata,
    input  logic [7:0]                  reg_rdata,
    output logic                        cfg_we,
    output logic [CFG_AW-1:0]           cfg_addr,
    output logic [7:0]                  cfg_wdata,
    input  logic [7:0]                  cfg_rdata,
    output logic                        cmd_stb,
    output logic [5:0]                  cmd_code,
    input  logic                        core_push,
    input  logic [7:0]                  core_wdata,
    input  logic                        core_pop,
    output logic [7:0]                  core_rdata,
    output logic [$clog2(FIFO_DEPTH):0] fifo_level,
    output logic                        fifo_ovf,
    output logic                        fifo_udf
);

    logic       rx_valid, frame_end, tx_load, bit_start;
    logic [7:0] rx_byte, tx_byte;
    logic       spi_push, spi_pop, fifo_empty;
    logic [7:0] spi_wdata;

    spi_dec_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .tx_byte   (tx_byte),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .frame_end (frame_end),
        .tx_load   (tx_load),
        .bit_start (bit_start)
    );

    spi_dec_ctrl #(
        .CFG_AW     (CFG_AW),
        .CFG_F_BASE (CFG_F_BASE),
        .CFG_T_BASE (CFG_T_BASE),
        .ALT_CMD    (ALT_CMD),
        .TEST_CMD   (TEST_CMD)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .frame_end  (frame_end),
        .tx_load    (tx_load),
        .bit_start  (bit_start),
        .tx_byte    (tx_byte),
        .reg_we     (reg_we),
        .reg_bank   (reg_bank),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cmd_stb    (cmd_stb),
        .cmd_code   (cmd_code),
        .fifo_push  (spi_push),
        .fifo_wdata (spi_wdata),
        .fifo_pop   (spi_pop),
        .fifo_head  (core_rdata),
        .fifo_empty (fifo_empty)
    );

    spi_dec_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (spi_push | core_push),
        .wdata (spi_push ? spi_wdata : core_wdata),
        .pop   (spi_pop | core_pop),
        .rdata (core_rdata),
        .level (fifo_level),
        .empty (fifo_empty),
        .ovf   (fifo_ovf),
        .udf   (fifo_udf)
    );

endmodule

// File: tb/spi_fe_decoder_bench.sv
// Bench for spi_fe_decoder. A behavioural model keeps expected strobe events
// and a FIFO queue. Every clock, each strobe is compared with the next
// expected event.
module spi_fe_decoder_bench;

    localparam int HP = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;
    logic reg_we, cfg_we, cmd_stb;
    logic [1:0] reg_bank;
    logic [5:0] reg_addr, cmd_code, cfg_addr;
    logic [7:0] reg_wdata, reg_rdata, cfg_wdata, cfg_rdata;
    logic core_push, core_pop;
    logic [7:0] core_wdata, core_rdata;
    logic [9:0] fifo_level;
    logic fifo_ovf, fifo_udf;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] ev_q[$];
    string       tag_q[$];
    logic [7:0]  tx_q[$];
    logic [7:0]  rx_q[$];
    logic [7:0]  fq[$];

    always #5 clk = ~clk;

    function automatic logic [7:0] rd_val(input logic [1:0] b, input logic [5:0] a);
        return {b, a} ^ 8'h96;
    endfunction

    assign reg_rdata = rd_val(reg_bank, reg_addr);
    assign cfg_rdata = {2'b00, cfg_addr} * 8'd5 + 8'd3;

    spi_fe_decoder u_spi_fe_decoder (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .reg_we(reg_we), .reg_bank(reg_bank), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cmd_stb(cmd_stb), .cmd_code(cmd_code),
        .core_push(core_push), .core_wdata(core_wdata), .core_pop(core_pop),
        .core_rdata(core_rdata), .fifo_level(fifo_level),
        .fifo_ovf(fifo_ovf), .fifo_udf(fifo_udf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input int bank, input int addr,
                             input int data, input string tag);
        ev_q.push_back({8'(kind), 8'(bank), 8'(addr), 8'(data)});
        tag_q.push_back(tag);
    endtask

    task automatic match(input logic [31:0] act);
        if (ev_q.size() == 0) begin
            chk("R11 R12 no unexpected strobe", act, 32'hFFFF_FFFF);
        end else begin
            logic [31:0] e;
            string t;
            e = ev_q.pop_front();
            t = tag_q.pop_front();
            chk(t, act, e);
        end
    endtask

    // Per-clock comparison of every strobe against the model's event list.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (reg_we)  match({8'd1, 6'd0, reg_bank, 2'd0, reg_addr, reg_wdata});
            if (cfg_we)  match({8'd2, 8'd0, 2'd0, cfg_addr, cfg_wdata});
            if (cmd_stb) match({8'd3, 8'd0, 8'd0, 2'd0, cmd_code});
        end
    end

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic spi_frame(input int partial);
        rx_q.delete();
        spi_cs_n = 1'b0;
        hp();
        foreach (tx_q[i]) begin
            logic [7:0] r;
            for (int b = 7; b >= 0; b--) begin
                spi_mosi = tx_q[i][b];
                hp();
                r[b] = spi_miso;
                spi_sclk = 1'b1;
                hp();
                spi_sclk = 1'b0;
            end
            rx_q.push_back(r);
        end
        for (int b = 0; b < partial; b++) begin
            spi_mosi = b[0];
            hp();
            spi_sclk = 1'b1;
            hp();
            spi_sclk = 1'b0;
        end
        hp();
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        hp();
        hp();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; spi_cs_n = 1'b1; spi_sclk = 1'b0; spi_mosi = 1'b0;
        core_push = 1'b0; core_pop = 1'b0; core_wdata = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk("R1 miso", 32'(spi_miso), 0);
        chk("R1 level", 32'(fifo_level), 0);
        chk("R1 flags", {30'd0, fifo_ovf, fifo_udf}, 0);
        chk("R1 strobes", {29'd0, reg_we, cfg_we, cmd_stb}, 0);

        // R2 write burst from address 5
        expect_ev(1, 0, 5, 8'hAA, "R2 write a");
        expect_ev(1, 0, 6, 8'hBB, "R2 write b");
        expect_ev(1, 0, 7, 8'hCC, "R2 write c");
        tx_q = '{8'h05, 8'hAA, 8'hBB, 8'hCC};
        spi_frame(0);

        // R3 read burst with 6-bit wrap
        tx_q = '{8'h7E, 8'h00, 8'h00, 8'h00};
        spi_frame(0);
        chk("R3 read 62", 32'(rx_q[1]), 32'(rd_val(0, 62)));
        chk("R3 read 63", 32'(rx_q[2]), 32'(rd_val(0, 63)));
        chk("R3 read wrap", 32'(rx_q[3]), 32'(rd_val(0, 0)));

        // R4 direct command then a fresh write in the same frame
        expect_ev(3, 0, 0, 8'h01, "R4 command");
        expect_ev(1, 0, 2, 8'h11, "R4 decode after command");
        tx_q = '{8'hC1, 8'h02, 8'h11};
        spi_frame(0);

        // R5 alternate bank read and write
        tx_q = '{8'hFB, 8'h43, 8'h00, 8'h00};
        spi_frame(0);
        chk("R5 alt read 3", 32'(rx_q[2]), 32'(rd_val(1, 3)));
        chk("R5 alt read 4", 32'(rx_q[3]), 32'(rd_val(1, 4)));
        expect_ev(1, 1, 16, 8'h77, "R5 alt write a");
        expect_ev(1, 1, 17, 8'h78, "R5 alt write b");
        tx_q = '{8'hFB, 8'h10, 8'h77, 8'h78};
        spi_frame(0);
        tx_q = '{8'hFB};
        spi_frame(0);
        expect_ev(1, 0, 16, 8'h99, "R5 prefix cleared at frame end");
        tx_q = '{8'h10, 8'h99};
        spi_frame(0);

        // R6 test bank single byte
        expect_ev(1, 2, 32, 8'h55, "R6 test write");
        tx_q = '{8'hFC, 8'h20, 8'h55, 8'h66};
        spi_frame(0);
        tx_q = '{8'hFC, 8'h45, 8'h00, 8'h00};
        spi_frame(0);
        chk("R6 test read", 32'(rx_q[2]), 32'(rd_val(2, 5)));
        chk("R6 test read extra", 32'(rx_q[3]), 0);

        // R7 FIFO load
        tx_q = '{8'h80, 8'h01, 8'h02, 8'h03};
        spi_frame(0);
        fq.push_back(8'h01); fq.push_back(8'h02); fq.push_back(8'h03);
        chk("R7 level after load", 32'(fifo_level), 32'(fq.size()));

        // R8 FIFO read past empty
        tx_q = '{8'h9F, 8'h00, 8'h00, 8'h00, 8'h00};
        spi_frame(0);
        for (int i = 1; i <= 4; i++) begin
            logic [7:0] e;
            e = (fq.size() > 0) ? fq.pop_front() : 8'h00;
            chk("R8 fifo read byte", 32'(rx_q[i]), 32'(e));
        end
        chk("R8 underflow flag", 32'(fifo_udf), 1);
        chk("R8 level empty", 32'(fifo_level), 0);
        chk("R7 no overflow yet", 32'(fifo_ovf), 0);

        // R7 overflow: fill through the core port, then one more over SPI
        for (int i = 0; i < 512; i++) begin
            core_push = 1'b1;
            core_wdata = 8'(i);
            fq.push_back(8'(i));
            @(negedge clk);
        end
        core_push = 1'b0;
        @(negedge clk);
        chk("R7 level full", 32'(fifo_level), 512);
        tx_q = '{8'h80, 8'hEE};
        spi_frame(0);
        chk("R7 overflow flag", 32'(fifo_ovf), 1);
        chk("R7 level unchanged when full", 32'(fifo_level), 512);
        tx_q = '{8'h9F, 8'h00, 8'h00};
        spi_frame(0);
        chk("R8 read oldest 0", 32'(rx_q[1]), 32'(fq.pop_front()));
        chk("R8 read oldest 1", 32'(rx_q[2]), 32'(fq.pop_front()));
        chk("R8 level after read", 32'(fifo_level), 510);
        chk("R8 head show-ahead", 32'(core_rdata), 32'(fq[0]));

        // R9 configuration loads at three bases
        expect_ev(2, 0, 0, 8'h21, "R9 cfg A 0");
        expect_ev(2, 0, 1, 8'h22, "R9 cfg A 1");
        tx_q = '{8'hA0, 8'h21, 8'h22};
        spi_frame(0);
        expect_ev(2, 0, 15, 8'h31, "R9 cfg F base");
        tx_q = '{8'hA8, 8'h31};
        spi_frame(0);
        expect_ev(2, 0, 36, 8'h41, "R9 cfg T base");
        expect_ev(2, 0, 37, 8'h42, "R9 cfg T next");
        tx_q = '{8'hAC, 8'h41, 8'h42};
        spi_frame(0);

        // R10 readback with leading dummy byte
        tx_q = '{8'hBF, 8'h00, 8'h00, 8'h00};
        spi_frame(0);
        chk("R10 dummy", 32'(rx_q[1]), 0);
        chk("R10 cfg 0", 32'(rx_q[2]), 3);
        chk("R10 cfg 1", 32'(rx_q[3]), 8);

        // R11 truncated bytes do nothing; the next frame decodes
        tx_q = '{8'h08};
        spi_frame(4);
        tx_q = '{8'h80};
        spi_frame(5);
        chk("R11 level after cut push", 32'(fifo_level), 510);
        expect_ev(1, 0, 8, 8'h33, "R11 recovery write");
        tx_q = '{8'h08, 8'h33};
        spi_frame(0);

        // R12 unlisted special byte
        tx_q = '{8'h85, 8'h01, 8'h02};
        spi_frame(0);
        chk("R12 miso zero", {24'd0, rx_q[1] | rx_q[2]}, 0);
        chk("R12 level unchanged", 32'(fifo_level), 510);

        repeat (20) @(negedge clk);
        chk("R2 all expected strobes seen", 32'(ev_q.size()), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule